// File: doc/BRIEF.md
# Truncated Timestamp Wrap Reconstructor

Event timestamps captured by a port often keep only the low bits of a free-running 64-bit tick counter, because a shorter field is cheaper to latch and to carry. This block turns such a truncated stamp back into a full 64-bit counter value. Each request carries the truncated stamp, a full counter value sampled after the stamp was captured, and a select that says whether the stamp holds 24 or 32 valid bits. One clock later the block returns the rebuilt 64-bit value with its own valid strobe.

The rebuilt value takes every counter bit above the selected width and fills the low bits with the stamp. If the counter's low field has not yet moved past the stamp, the counter has wrapped since the capture, and one wrap period (2^width ticks) is subtracted. Equality counts as a wrap. The result is only correct when the counter sample lies within one wrap period after the capture. At 8 ns per tick that period is about 0.134 s for the 24-bit mode and about 34.4 s for the 32-bit mode. Meeting it is the caller's job.

Top module: `rts_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `out_ts` is 0.
- R2: `out_valid` is high in exactly those cycles that follow a cycle in which `in_valid` was high.
- R3: With `in_wide`=0 (24-bit mode), when the counter's low 24 bits are greater than the stamp's low 24 bits, `out_ts` equals counter bits 63..24 followed by stamp bits 23..0.
- R4: With `in_wide`=1 (32-bit mode), when the counter's low 32 bits are greater than the stamp, `out_ts` equals counter bits 63..32 followed by the 32 stamp bits.
- R5: When the counter's low field (24 or 32 bits, per mode) is less than the masked stamp, the merged value of R3/R4 minus 2^24 (24-bit mode) or minus 2^32 (32-bit mode) is output.
- R6: When the counter's low field equals the masked stamp, the wrap correction of R5 is applied.
- R7: In 24-bit mode, stamp bits 31..24 have no effect on `out_ts`.
- R8: The mode is taken from `in_wide` of each request, so back-to-back requests in different modes each use their own width.
- R9: In a cycle that follows a cycle without `in_valid`, `out_ts` keeps its previous value whatever the other inputs did.
- R10: The subtraction wraps modulo 2^64, so a wrap correction when the counter's upper bits are all zero gives 2^64 + merged − 2^width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the other inputs are sampled when high |
| in_wide | input | 1 | 0 selects 24-bit stamps, 1 selects 32-bit stamps |
| in_stamp | input | 32 | Truncated stamp; bits above the selected width are ignored |
| in_now | input | 64 | Counter value sampled after the stamp was captured |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_ts | output | 64 | Reconstructed 64-bit timestamp; holds between results |

## Verification
Every result is due exactly one clock after the request. That clock is the edge at which the request's inputs are captured into the output register, so nothing reaches the outputs combinationally. The bench drives each request just after a falling edge and pushes the value it expects into a queue. The monitor samples 2 ns after the following rising edge, so it always reads the register after it has settled. In a cycle with `out_valid` high, the monitor pops and compares one item. In a cycle with `out_valid` low, it checks that the queue is empty and that `out_ts` has not moved, which is how the hold and ignore behaviours are seen at the ports.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int unsigned CNT_W = 64;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } rts_mode_e;
endpackage

// File: rtl/rts_merge.sv
module rts_merge
  import rts_pkg::*;
#(
  parameter int unsigned NARROW_W = 24,
  parameter int unsigned WIDE_W   = 32
) (
  input  logic              wide,
  input  logic [WIDE_W-1:0] stamp,
  input  cnt_t              now,
  output cnt_t              merged,
  output logic              wrap
);
  // Low fields, with the bits above the selected width forced to zero.
  logic [WIDE_W-1:0] stamp_low;
  logic [WIDE_W-1:0] now_low;

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    if (i < NARROW_W) begin : g_always_low
      assign stamp_low[i] = stamp[i];
      assign now_low[i]   = now[i];
      assign merged[i]    = stamp[i];
    end else if (i < WIDE_W) begin : g_mode_low
      assign stamp_low[i] = wide & stamp[i];
      assign now_low[i]   = wide & now[i];
      assign merged[i]    = wide ? stamp[i] : now[i];
    end else begin : g_high
      assign merged[i] = now[i];
    end
  end

  // Not yet past the stamp, or level with it: the counter has wrapped.
  assign wrap = (now_low <= stamp_low);
endmodule

// File: rtl/rts_adjust.sv
module rts_adjust
  import rts_pkg::*;
#(
  parameter int unsigned NARROW_W = 24,
  parameter int unsigned WIDE_W   = 32
) (
  input  logic wide,
  input  logic wrap,
  input  cnt_t merged,
  output cnt_t result
);
  localparam cnt_t PERIOD_NARROW = cnt_t'(1) << NARROW_W;
  localparam cnt_t PERIOD_WIDE   = cnt_t'(1) << WIDE_W;

  cnt_t period;

  always_comb begin
    period = (wide == MODE_WIDE) ? PERIOD_WIDE : PERIOD_NARROW;
    result = wrap ? (merged - period) : merged;
  end
endmodule

// File: rtl/rts_reg.sv
module rts_reg
  import rts_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  cnt_t in_ts,
  output logic out_valid,
  output cnt_t out_ts
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ts    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_ts <= in_ts;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_ts == '0));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_ts));
endmodule

// File: rtl/rts_top.sv
module rts_top
  import rts_pkg::*;
#(
  parameter int unsigned NARROW_W = 24,
  parameter int unsigned WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [WIDE_W-1:0] in_stamp,
  input  logic [63:0]       in_now,
  output logic              out_valid,
  output logic [63:0]       out_ts
);
  cnt_t merged;
  cnt_t result;
  logic wrap;

  rts_merge #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_merge (
    .wide   (in_wide),
    .stamp  (in_stamp),
    .now    (in_now),
    .merged (merged),
    .wrap   (wrap)
  );

  rts_adjust #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_adjust (
    .wide   (in_wide),
    .wrap   (wrap),
    .merged (merged),
    .result (result)
  );

  rts_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ts     (result),
    .out_valid (out_valid),
    .out_ts    (out_ts)
  );

  // The wrap correction never touches the stamp's own bits.
  p_low_bits_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_ts[NARROW_W-1:0] == $past(in_stamp[NARROW_W-1:0]));

  p_wide_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_wide) |=> out_ts[WIDE_W-1:0] == $past(in_stamp));
endmodule

// File: tb/sim_rts_top.sv
module sim_rts_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_wide = 1'b0;
  logic [31:0] in_stamp = '0;
  logic [63:0] in_now = '0;
  logic        out_valid;
  logic [63:0] out_ts;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_ts = '0;
  logic        mon_en = 1'b0;

  always #4 clk = ~clk;

  rts_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
    .in_stamp(in_stamp), .in_now(in_now),
    .out_valid(out_valid), .out_ts(out_ts)
  );

  function automatic logic [63:0] model(bit wide, logic [31:0] s, logic [63:0] n);
    int unsigned w;
    logic [63:0] m, sm, r;
    w  = wide ? 32 : 24;
    m  = (64'd1 << w) - 64'd1;
    sm = {32'd0, s} & m;
    r  = (n & ~m) | sm;
    if ((n & m) <= sm) r = r - (64'd1 << w);
    return r;
  endfunction

  task automatic send(bit wide, logic [31:0] s, logic [63:0] n, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_wide  = wide;
    in_stamp = s;
    in_now   = n;
    exp_q.push_back(model(wide, s, n));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_wide  = ~in_wide;
      in_stamp = in_stamp ^ 32'hA5A5_3C3C;
      in_now   = in_now + 64'h1234_5678_9ABC;
    end
  endtask

  // Monitor: results land one edge after the request; sample 2 ns later.
  always @(posedge clk) begin
    #2;
    cycles++;
    if (mon_en) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2: unexpected out_valid, out_ts=%h expected no result", out_ts);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_ts !== e) begin
            fails++;
            $display("FAIL %s: out_ts=%h expected %h", t, out_ts, e);
          end
        end
      end else begin
        checks++;
        if (exp_q.size() != 0) begin
          fails++;
          $display("FAIL R2: out_valid=0 expected 1 (%0d pending)", exp_q.size());
        end
        checks++;
        if (out_ts !== last_ts) begin
          fails++;
          $display("FAIL R9: out_ts=%h expected held %h", out_ts, last_ts);
        end
      end
      last_ts = out_ts;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_ts !== 64'd0) begin
      fails++;
      $display("FAIL R1: out_valid=%b out_ts=%h expected 0 0", out_valid, out_ts);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_ts !== 64'd0) begin
      fails++;
      $display("FAIL R1: after reset out_valid=%b out_ts=%h expected 0 0", out_valid, out_ts);
    end
    mon_en = 1'b1;

    // R3: narrow mode, no wrap
    send(1'b0, 32'h007F_FFF0, 64'h0000_0012_3480_0000, "R3");
    idle(2);
    // R4: wide mode, no wrap
    send(1'b1, 32'h1234_5678, 64'hDEAD_BEEF_8000_0000, "R4");
    idle(1);
    // R5: wrap in each mode
    send(1'b0, 32'h00FF_FF00, 64'h0000_0000_0500_0010, "R5");
    idle(1);
    send(1'b1, 32'hF000_0000, 64'h0000_0007_0000_0100, "R5");
    idle(1);
    // R6: equality counts as a wrap
    send(1'b0, 32'h0012_3456, 64'h0000_0100_0012_3456, "R6");
    idle(1);
    send(1'b1, 32'h89AB_CDEF, 64'h0000_0003_89AB_CDEF, "R6");
    idle(1);
    // R7: upper stamp bits ignored in narrow mode (both give the same result)
    send(1'b0, 32'h00AB_CDEF, 64'h0000_0055_00F0_0000, "R7");
    send(1'b0, 32'hFFAB_CDEF, 64'h0000_0055_00F0_0000, "R7");
    send(1'b0, 32'h5AAB_CDEF, 64'h0000_0055_00A0_0000, "R7");
    idle(2);
    // R8: back-to-back requests alternating modes
    send(1'b1, 32'h00C0_0000, 64'h0000_0009_00D0_0000, "R8");
    send(1'b0, 32'h00C0_0000, 64'h0000_0009_00D0_0000, "R8");
    send(1'b1, 32'h00E0_0000, 64'h0000_0009_00D0_0000, "R8");
    send(1'b0, 32'h00E0_0000, 64'h0000_0009_00D0_0000, "R8");
    idle(3);
    // R10: wrap correction with zero upper bits wraps modulo 2^64
    send(1'b0, 32'h0000_0020, 64'h0000_0000_0000_0010, "R10");
    idle(1);
    send(1'b1, 32'hFFFF_FFFF, 64'h0000_0000_0000_0001, "R10");
    idle(4);
    // R9: long idle with changing inputs, output must hold
    idle(6);

    mon_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule